// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. It works only as a slave: the bit clock clocks the block, and the frame clock and the serial data line are sampled on each rising bit-clock edge. It creates no clocks of its own. A two-bit configuration code chooses the framing. The choices are right-justified with 16-bit words, right-justified with 24-bit words, left-justified with 24-bit words, and the standard inter-IC sound layout with 24-bit words.

Each completed frame gives a left and a right sample on 24-bit outputs, together with a one-cycle strobe. Words always arrive most significant bit first. A 16-bit word is placed in the top of the 24-bit output and its bottom byte is zero. The block stays silent until it has seen one frame-clock transition after reset, so a partial half-frame at start-up never reaches the outputs.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high, and after it until the first strobe, both sample outputs read zero and the strobe is low.
- R2: With code 00, each sample is the last 16 bits before the frame-clock edge that closes its half-frame. It appears as bits 23:8 of the output, bits 7:0 read zero, and frame clock high marks the left half.
- R3: With code 01, each sample is the last 24 bits before the frame-clock edge that closes its half-frame, and frame clock high marks the left half.
- R4: With code 10, the most significant bit is the bit sampled on the first rising edge that sees the new frame-clock level. The next 23 bits follow it, and frame clock high marks the left half.
- R5: With code 11, the most significant bit is the bit sampled one rising edge after the edge that first sees the new frame-clock level. The next 23 bits follow it, and frame clock low marks the left half.
- R6: The strobe is high for exactly one cycle per frame, after the right sample is complete. It carries the left sample of the same frame. A right half with no left half before it produces no strobe.
- R7: Between strobes both sample outputs keep their values.
- R8: Bits of a half-frame outside the sample window have no effect on the outputs. For right-justified codes these are the bits before the window; for the other codes they are the bits after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Frame (channel select) clock |
| sdata_in | input | 1 | Serial data, most significant bit first |
| fmt_sel | input | 2 | Framing code: 00 RJ16, 01 RJ24, 10 LJ24, 11 I2S24 |
| left_out | output | 24 | Left sample of the last completed frame |
| right_out | output | 24 | Right sample of the last completed frame |
| sample_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
A bit counter that is off by one shows up at the ports at the first strobe after the lock edge. The sample then reads as the expected word shifted by one place, with a padding bit entering at one end. A wrong channel decision or a missed lock edge instead shows as a missing strobe, a doubled strobe, or left and right swapped, again within the first frame. Random padding outside each window makes any leak of those bits corrupt the low or high bits of the very next strobed pair.

// File: rtl/sar_pkg.sv
package sar_pkg;

    parameter int SAMPLE_W = 24;
    parameter int SHORT_W  = 16;

    typedef enum logic [1:0] {
        FMT_RJ16  = 2'b00,
        FMT_RJ24  = 2'b01,
        FMT_LJ24  = 2'b10,
        FMT_I2S24 = 2'b11
    } fmt_e;

    typedef struct packed {
        logic                fire;
        logic                is_left;
        logic [SAMPLE_W-1:0] word;
    } cap_t;

    // Frame-clock level that marks the left half-frame.
    function automatic logic left_level(fmt_e f);
        return (f == FMT_I2S24) ? 1'b0 : 1'b1;
    endfunction

    // Bit slots between the frame-clock edge and the MSB.
    function automatic int lead_slots(fmt_e f);
        return (f == FMT_I2S24) ? 1 : 0;
    endfunction

    function automatic logic is_right_just(fmt_e f);
        return (f == FMT_RJ16) || (f == FMT_RJ24);
    endfunction

endpackage

// File: rtl/sar_frame_track.sv
module sar_frame_track #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_clk,
    output logic             edge_now,
    output logic             locked,
    output logic             lr_prev,
    output logic [CNT_W-1:0] idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             primed_q;
    logic [CNT_W-1:0] cnt_q;

    assign edge_now = primed_q && (frame_clk != lr_prev);
    assign idx      = edge_now ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            lr_prev  <= 1'b0;
            locked   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            primed_q <= 1'b1;
            lr_prev  <= frame_clk;
            if (edge_now) locked <= 1'b1;
            cnt_q <= (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
        end
    end
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         din,
    output logic [W-1:0] shreg
);
    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[W-2:0], din};
    end
endmodule

// File: rtl/sar_capture.sv
module sar_capture
    import sar_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  fmt_e                fmt,
    input  logic                edge_now,
    input  logic                locked,
    input  logic                lr_prev,
    input  logic                frame_clk,
    input  logic [CNT_W-1:0]    idx,
    input  logic [SAMPLE_W-1:0] shreg,
    input  logic                sdata,
    output cap_t                cap
);
    localparam int PAD_W = SAMPLE_W - SHORT_W;

    always_comb begin
        cap = '0;
        if (is_right_just(fmt)) begin
            // Closing edge: the register holds the half-frame just ended.
            cap.fire    = edge_now && locked;
            cap.is_left = (lr_prev == left_level(fmt));
            cap.word    = (fmt == FMT_RJ16)
                        ? {shreg[SHORT_W-1:0], {PAD_W{1'b0}}}
                        : shreg;
        end else begin
            cap.fire    = locked && !edge_now &&
                          (int'(idx) == SAMPLE_W - 1 + lead_slots(fmt));
            cap.is_left = (frame_clk == left_level(fmt));
            cap.word    = {shreg[SAMPLE_W-2:0], sdata};
        end
    end
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cap_t                cap,
    output logic [SAMPLE_W-1:0] left_q,
    output logic [SAMPLE_W-1:0] right_q,
    output logic                valid_q
);
    logic [SAMPLE_W-1:0] left_hold;
    logic                have_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_q    <= '0;
            right_q   <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (cap.fire && cap.is_left) begin
                left_hold <= cap.word;
                have_left <= 1'b1;
            end else if (cap.fire && have_left) begin
                left_q    <= left_hold;
                right_q   <= cap.word;
                valid_q   <= 1'b1;
                have_left <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
(
    input  logic                bit_clk,
    input  logic                rst,
    input  logic                frame_clk,
    input  logic                sdata_in,
    input  logic [1:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid
);
    localparam int CNT_W = $clog2(SAMPLE_W + 2);

    logic                edge_now, locked, lr_prev;
    logic [CNT_W-1:0]    idx;
    logic [SAMPLE_W-1:0] shreg;
    cap_t                cap;
    fmt_e                fmt;

    assign fmt = fmt_e'(fmt_sel);

    sar_frame_track #(.CNT_W(CNT_W)) u_track (
        .clk(bit_clk), .rst(rst), .frame_clk(frame_clk),
        .edge_now(edge_now), .locked(locked), .lr_prev(lr_prev), .idx(idx)
    );

    sar_shifter #(.W(SAMPLE_W)) u_shift (
        .clk(bit_clk), .rst(rst), .din(sdata_in), .shreg(shreg)
    );

    sar_capture #(.CNT_W(CNT_W)) u_cap (
        .fmt(fmt), .edge_now(edge_now), .locked(locked), .lr_prev(lr_prev),
        .frame_clk(frame_clk), .idx(idx), .shreg(shreg), .sdata(sdata_in),
        .cap(cap)
    );

    sar_out_stage u_out (
        .clk(bit_clk), .rst(rst), .cap(cap),
        .left_q(left_out), .right_q(right_out), .valid_q(sample_valid)
    );
endmodule

// File: rtl/sar_checker.sv
module sar_checker
    import sar_pkg::*;
(
    input logic                bit_clk,
    input logic                rst,
    input logic [1:0]          fmt_sel,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic                sample_valid
);
    // R1: reset clears the strobe
    a_r1_reset_quiet: assert property (@(posedge bit_clk)
        rst |=> !sample_valid);

    // R6: strobe never lasts two cycles
    a_r6_single_strobe: assert property (@(posedge bit_clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R7: outputs hold between strobes
    a_r7_hold_outputs: assert property (@(posedge bit_clk) disable iff (rst)
        !sample_valid |-> ($stable(left_out) && $stable(right_out)));

    // R2: short-word mode leaves the bottom byte zero
    a_r2_low_byte_zero: assert property (@(posedge bit_clk) disable iff (rst)
        (sample_valid && fmt_sel == 2'b00) |->
            (left_out[7:0] == 8'h00 && right_out[7:0] == 8'h00));
endmodule

bind serial_audio_rx sar_checker u_chk (
    .bit_clk(bit_clk), .rst(rst), .fmt_sel(fmt_sel),
    .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_clk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [23:0] left_out, right_out;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    bit done = 0;
    bit prev_valid = 0;
    string tag = "R1";
    logic [23:0] ql[$];
    logic [23:0] qr[$];
    logic [23:0] last_l = '0, last_r = '0;

    always #5 clk = ~clk;

    serial_audio_rx u_dut (
        .bit_clk(clk), .rst(rst), .frame_clk(frame_clk), .sdata_in(sdata),
        .fmt_sel(fmt), .left_out(left_out), .right_out(right_out),
        .sample_valid(sample_valid)
    );

    task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(logic [1:0] f, logic [23:0] raw);
        return (f == 2'b00) ? {raw[15:0], 8'h00} : raw;
    endfunction

    function automatic logic lvl_left(logic [1:0] f);
        return (f == 2'b11) ? 1'b0 : 1'b1;
    endfunction

    // Scoreboard: compare every strobe against the queued frame.
    always @(negedge clk) begin
        if (!rst) begin
            if (sample_valid) begin
                vcount++;
                check(!prev_valid, "R6 strobe width", 48'(prev_valid), 48'd0);
                if (ql.size() == 0) begin
                    check(1'b0, "R6 unexpected strobe", {left_out, right_out}, 48'd0);
                end else begin
                    logic [23:0] el, er;
                    el = ql.pop_front();
                    er = qr.pop_front();
                    check(left_out == el && right_out == er, tag,
                          {left_out, right_out}, {el, er});
                end
            end
            prev_valid = sample_valid;
        end else begin
            prev_valid = 0;
        end
    end

    task automatic send_half(logic level, logic [23:0] word, bit onespad);
        logic [31:0] pad, seq;
        pad = onespad ? 32'hFFFF_FFFF : $urandom;
        case (fmt)
            2'b00:   seq = {pad[15:0], word[15:0]};
            2'b01:   seq = {pad[7:0], word};
            2'b10:   seq = {word, pad[7:0]};
            default: seq = {pad[0], word, pad[6:0]};
        endcase
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk);
            frame_clk = level;
            sdata     = seq[i];
        end
    endtask

    task automatic send_frame(logic [23:0] l, logic [23:0] r, bit onespad);
        logic lv;
        lv = lvl_left(fmt);
        last_l = exp_word(fmt, l);
        last_r = exp_word(fmt, r);
        ql.push_back(last_l);
        qr.push_back(last_r);
        send_half(lv, l, onespad);
        send_half(!lv, r, onespad);
    endtask

    task automatic run_burst(logic [1:0] f, int n, bit onespad, string t);
        logic lv;
        int v0;
        lv = lvl_left(f);
        @(negedge clk);
        rst = 1'b1;
        fmt = f;
        frame_clk = !lv;
        repeat (3) @(negedge clk);
        // R1: reset clears outputs from the previous burst
        check(left_out == 0 && right_out == 0 && !sample_valid, "R1 reset state",
              {left_out, right_out}, 48'd0);
        rst = 1'b0;
        tag = t;
        v0 = vcount;
        // A right half with no left half before it must give no strobe (R6).
        send_half(!lv, 24'(32'($urandom)), onespad);
        check(vcount == v0, "R6 no strobe before first frame", 48'(vcount - v0), 48'd0);
        check(left_out == 0 && right_out == 0, "R1 zero until first strobe",
              {left_out, right_out}, 48'd0);
        send_frame(24'h000000, 24'hFFFFFF, onespad);
        send_frame(24'h800000, 24'h000001, onespad);
        for (int k = 0; k < n; k++)
            send_frame(24'(32'($urandom)), 24'(32'($urandom)), onespad);
        send_half(lv, 24'(32'($urandom)), onespad);
        repeat (8) @(negedge clk);
        check(vcount - v0 == n + 2, "R6 strobe count", 48'(vcount - v0), 48'(n + 2));
        check(ql.size() == 0, "R6 missing strobe", 48'(ql.size()), 48'd0);
        // R7: held values after the stream stops
        check(!sample_valid && left_out == last_l && right_out == last_r,
              "R7 hold", {left_out, right_out}, {last_l, last_r});
        ql.delete();
        qr.delete();
    endtask

    initial begin
        void'($urandom(32'h5EED_0A1D));
        repeat (3) @(negedge clk);
        check(left_out == 0 && right_out == 0 && !sample_valid, "R1 reset state",
              {left_out, right_out}, 48'd0);
        run_burst(2'b00, 20, 0, "R2 RJ16");
        run_burst(2'b01, 20, 0, "R3 RJ24");
        run_burst(2'b10, 20, 0, "R4 LJ24");
        run_burst(2'b11, 20, 0, "R5 I2S24");
        run_burst(2'b00, 6, 1, "R8 RJ16 ones padding");
        run_burst(2'b01, 6, 1, "R8 RJ24 ones padding");
        run_burst(2'b10, 6, 1, "R8 LJ24 ones padding");
        run_burst(2'b11, 6, 1, "R8 I2S24 ones padding");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule